// File: doc/BRIEF.md
# Memory wait-state timing calculator

This block turns a description of one memory access into the number of bus cycles that access costs. A request names the CPU (primary or secondary), the memory region code, the access width (16 or 32 bits) and whether the access is nonsequential or sequential. Each CPU has its own fixed table of region entries. An entry holds a bus type, a sequential delay S and a nonsequential delay N.

The cost follows from the bus type. A 32-bit bus charges the same for both widths. A 16-bit bus splits a 32-bit access into two halves, and the second half is always sequential. An 8-bit bus is, for now, charged like a 16-bit access. CPU-internal memory always costs one cycle. The primary CPU runs at a multiple of the bus clock, so its external delays are scaled by a left shift. The secondary CPU's delays are not scaled.

The lookup is registered. A valid request gives a result one clock later, and that result is held until the next request. A region index equal to the region count marks the end of the table and costs zero cycles. Any index beyond that also costs zero.

Top module: `wait_cost_calc`

## Requirements
- R1: While reset is asserted (rst_n low) and in the first cycle after it, rsp_valid is 0 and rsp_cycles is 0.
- R2: A request with req_valid high at a rising edge makes rsp_valid high for exactly the following cycle. Back-to-back requests give back-to-back results, and rsp_valid is low in every cycle whose preceding edge had no request.
- R3: While no request is accepted, rsp_cycles keeps the last result.
- R4: On bus type 0 (32-bit bus), both widths cost N when req_seq=0 and S when req_seq=1, scaled by the CPU's shift.
- R5: On bus type 1 (16-bit bus), a 16-bit access (req_wide=0) costs N or S. A 32-bit access (req_wide=1) costs N+S when nonsequential and S+S when sequential. Each result is scaled by the CPU's shift.
- R6: On bus type 3 (CPU-internal memory), every width/sequentiality combination costs exactly 1, and no shift is applied.
- R7: On bus type 2 (8-bit bus), a 32-bit access costs the same as a 16-bit access: N or S, scaled.
- R8: For the primary CPU (req_cpu=0), external delays are shifted left by CLK_SHIFT, which defaults to 1. For the secondary CPU (req_cpu=1), no shift is applied.
- R9: Primary table, written as region: type/S/N.
  - Regions 0, 1, 7, 8 and 15: 0/1/4.
  - Regions 2 to 5: type 3.
  - Region 6: 1/1/8.
  - Regions 9 to 14 and region 16: 1/1/4.
  - Region 17: 2/1/4.
  - There are 18 regions.
- R10: Secondary table, written as region: type/S/N.
  - Regions 0, 1, 3, 4 and 5: 0/1/1.
  - Region 2: 1/1/8.
  - Regions 6 to 9: 1/1/1.
  - Region 10: 2/1/1.
  - There are 11 regions.
- R11: A region index equal to or above the CPU's region count (18 primary, 11 secondary) costs 0 in all four combinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_cpu | input | 1 | 0 = primary CPU, 1 = secondary CPU |
| req_region | input | RGN_W (5) | Region code |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| req_seq | input | 1 | 1 = sequential, 0 = nonsequential |
| rsp_valid | output | 1 | Result valid, one cycle after a request |
| rsp_cycles | output | OUT_W (8) | Bus cycle count, held until the next request |

## Verification
Two functions can fall in the same cycle: presenting one result and capturing the next request. The second request may come from the other CPU and need a different shift. The bench provokes this with unbroken request streams that switch CPU, width and sequentiality every cycle, including a switch straight onto and off a sentinel index. A scoreboard checks each response against the value expected for its own request, so any sticky or late value from a neighbouring request is caught. The hold rule is judged in idle gaps placed between bursts.

// File: rtl/wsc_pkg.sv
`timescale 1ns/1ps
package wsc_pkg;

   localparam int DLY_W = 4;

   typedef enum logic [1:0] {
      BUS_W32 = 2'd0,
      BUS_W16 = 2'd1,
      BUS_W8  = 2'd2,
      BUS_INT = 2'd3
   } bus_kind_t;

   typedef struct packed {
      bus_kind_t        kind;
      logic [DLY_W-1:0] dly_s;
      logic [DLY_W-1:0] dly_n;
   } rgn_timing_t;

   function automatic rgn_timing_t mk(bus_kind_t k, int s, int n);
      rgn_timing_t e;
      e.kind  = k;
      e.dly_s = DLY_W'(s);
      e.dly_n = DLY_W'(n);
      return e;
   endfunction

   // primary CPU table
   function automatic rgn_timing_t pri_entry(int idx);
      case (idx)
         2, 3, 4, 5:                  return mk(BUS_INT, 0, 0);
         6:                           return mk(BUS_W16, 1, 8);
         9, 10, 11, 12, 13, 14, 16:   return mk(BUS_W16, 1, 4);
         17:                          return mk(BUS_W8,  1, 4);
         default:                     return mk(BUS_W32, 1, 4);
      endcase
   endfunction

   // secondary CPU table
   function automatic rgn_timing_t sec_entry(int idx);
      case (idx)
         2:                           return mk(BUS_W16, 1, 8);
         6, 7, 8, 9:                  return mk(BUS_W16, 1, 1);
         10:                          return mk(BUS_W8,  1, 1);
         default:                     return mk(BUS_W32, 1, 1);
      endcase
   endfunction

endpackage

// File: rtl/wsc_region_rom.sv
`timescale 1ns/1ps
module wsc_region_rom
   import wsc_pkg::*;
#(
   parameter int NUM_RGN = 18,
   parameter int RGN_W   = 5,
   parameter bit IS_PRI  = 1'b1
) (
   input  logic [RGN_W-1:0] idx,
   output rgn_timing_t      ent,
   output logic             in_range
);

   initial begin : elab_chk
      AST_RGN_FITS: assert (NUM_RGN >= 1 && NUM_RGN < (1 << RGN_W))
         else $error("region count does not fit index width"); // R11
   end

   assign in_range = (int'(idx) < NUM_RGN);

   generate
      if (IS_PRI) begin : g_pri
         always_comb begin
            ent = in_range ? pri_entry(int'(idx)) : '0;
         end
      end else begin : g_sec
         always_comb begin
            ent = in_range ? sec_entry(int'(idx)) : '0;
         end
      end
   endgenerate

endmodule

// File: rtl/wsc_cost_rule.sv
`timescale 1ns/1ps
module wsc_cost_rule
   import wsc_pkg::*;
#(
   parameter int SHIFT = 1,
   parameter int OUT_W = 8
) (
   input  rgn_timing_t      ent,
   input  logic             in_range,
   input  logic             wide,
   input  logic             seq,
   output logic [OUT_W-1:0] cost
);

   localparam int MAX_BASE = 2 * ((1 << DLY_W) - 1);

   initial begin : elab_chk
      AST_COST_FITS: assert ((MAX_BASE << SHIFT) < (1 << OUT_W))
         else $error("shifted worst-case cost overflows output"); // R8
   end

   logic [OUT_W-1:0] s_ext;
   logic [OUT_W-1:0] n_ext;
   logic [OUT_W-1:0] base;

   assign s_ext = OUT_W'(ent.dly_s);
   assign n_ext = OUT_W'(ent.dly_n);

   always_comb begin
      if (wide && ent.kind == BUS_W16) begin
         base = seq ? (s_ext + s_ext) : (n_ext + s_ext);
      end else begin
         base = seq ? s_ext : n_ext;
      end
   end

   always_comb begin
      if (!in_range) begin
         cost = '0;
      end else if (ent.kind == BUS_INT) begin
         cost = OUT_W'(1);
      end else begin
         cost = base << SHIFT;
      end
   end

endmodule

// File: rtl/wait_cost_calc.sv
`timescale 1ns/1ps
module wait_cost_calc
   import wsc_pkg::*;
#(
   parameter int NUM_RGN_PRI = 18,
   parameter int NUM_RGN_SEC = 11,
   parameter int RGN_W       = 5,
   parameter int CLK_SHIFT   = 1,
   parameter int OUT_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_cpu,
   input  logic [RGN_W-1:0] req_region,
   input  logic             req_wide,
   input  logic             req_seq,
   output logic             rsp_valid,
   output logic [OUT_W-1:0] rsp_cycles
);

   localparam int NUM_CPU = 2;

   initial begin : elab_chk
      AST_SHIFT_RANGE: assert (CLK_SHIFT >= 0 && CLK_SHIFT <= 3)
         else $error("clock shift out of range"); // R8
   end

   logic [OUT_W-1:0] cost_by_cpu [NUM_CPU];
   logic             rng_by_cpu  [NUM_CPU];

   generate
      for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
         rgn_timing_t ent;
         wsc_region_rom #(
            .NUM_RGN (c == 0 ? NUM_RGN_PRI : NUM_RGN_SEC),
            .RGN_W   (RGN_W),
            .IS_PRI  (c == 0)
         ) u_rom (
            .idx      (req_region),
            .ent      (ent),
            .in_range (rng_by_cpu[c])
         );
         wsc_cost_rule #(
            .SHIFT (c == 0 ? CLK_SHIFT : 0),
            .OUT_W (OUT_W)
         ) u_rule (
            .ent      (ent),
            .in_range (rng_by_cpu[c]),
            .wide     (req_wide),
            .seq      (req_seq),
            .cost     (cost_by_cpu[c])
         );
      end
   endgenerate

   logic             sel_in_range;
   logic [OUT_W-1:0] sel_cost;

   assign sel_in_range = rng_by_cpu[req_cpu];
   assign sel_cost     = cost_by_cpu[req_cpu];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_cycles <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_cycles <= sel_cost;
         end
      end
   end

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R2

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && $stable(rsp_cycles))); // R3

   AST_SENTINEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !$past(sel_in_range)) |-> (rsp_cycles == '0)); // R11

   AST_REAL_RGN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(sel_in_range)) |-> (rsp_cycles != '0)); // R9

endmodule

// File: tb/wait_cost_calc_tb.sv
`timescale 1ns/1ps
module wait_cost_calc_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_cpu = 1'b0;
   logic [4:0] req_region = '0;
   logic       req_wide = 1'b0;
   logic       req_seq = 1'b0;
   logic       rsp_valid;
   logic [7:0] rsp_cycles;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   int    exp_q [$];
   string tag_q [$];
   logic [7:0] last_seen = '0;

   always #4 clk = ~clk;

   wait_cost_calc u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cpu(req_cpu),
      .req_region(req_region), .req_wide(req_wide), .req_seq(req_seq),
      .rsp_valid(rsp_valid), .rsp_cycles(rsp_cycles)
   );

   function automatic void entry(int cpu, int rgn, output int k, output int s, output int n);
      s = 1;
      if (cpu == 0) begin
         case (rgn)
            2, 3, 4, 5:                k = 3;
            6:         begin k = 1; n = 8; end
            17:        begin k = 2; n = 4; end
            0, 1, 7, 8, 15: begin k = 0; n = 4; end
            default:   begin k = 1; n = 4; end
         endcase
         if (k == 3) n = 0;
      end else begin
         case (rgn)
            2:          begin k = 1; n = 8; end
            6, 7, 8, 9: begin k = 1; n = 1; end
            10:         begin k = 2; n = 1; end
            default:    begin k = 0; n = 1; end
         endcase
      end
   endfunction

   function automatic int bench_cost(int cpu, int rgn, bit wide, bit seq);
      int k, s, n, base;
      if (rgn >= ((cpu == 0) ? 18 : 11)) return 0;
      entry(cpu, rgn, k, s, n);
      if (k == 3) return 1;
      if (wide && k == 1) base = seq ? (s + s) : (n + s);
      else base = seq ? s : n;
      return base << ((cpu == 0) ? 1 : 0);
   endfunction

   function automatic string bench_tag(int cpu, int rgn);
      int k, s, n;
      string t;
      if (rgn >= ((cpu == 0) ? 18 : 11)) return "R11";
      entry(cpu, rgn, k, s, n);
      case (k)
         0: t = "R4";
         1: t = "R5";
         2: t = "R7";
         default: t = "R6";
      endcase
      return (cpu == 0) ? {t, "/R8/R9"} : {t, "/R8/R10"};
   endfunction

   task automatic send(int cpu, int rgn, bit wide, bit seq);
      @(negedge clk);
      req_valid  = 1'b1;
      req_cpu    = cpu[0];
      req_region = rgn[4:0];
      req_wide   = wide;
      req_seq    = seq;
      exp_q.push_back(bench_cost(cpu, rgn, wide, seq));
      tag_q.push_back(bench_tag(cpu, rgn));
   endtask

   task automatic idle(int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
         req_region = 5'd31;
         req_wide = ~req_wide;
      end
   endtask

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (!rst_n) begin
            check(rsp_valid == 1'b0, "R1 valid", int'(rsp_valid), 0);
            check(rsp_cycles == 8'd0, "R1 cycles", int'(rsp_cycles), 0);
         end else if (exp_q.size() > 0) begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rsp_valid == 1'b1, "R2 valid", int'(rsp_valid), 1);
            check(int'(rsp_cycles) == e, t, int'(rsp_cycles), e);
            last_seen = rsp_cycles;
         end else begin
            check(rsp_valid == 1'b0, "R2 no spurious valid", int'(rsp_valid), 0);
            check(rsp_cycles == last_seen, "R3 hold", int'(rsp_cycles), int'(last_seen));
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      // R9 R5 R8 spot values: primary main RAM
      send(0, 6, 1'b1, 1'b0);
      send(0, 6, 1'b1, 1'b1);
      send(0, 6, 1'b0, 1'b0);
      idle(3);
      // R10 secondary main RAM, R6 internal
      send(1, 2, 1'b1, 1'b0);
      send(0, 3, 1'b1, 1'b0);
      send(1, 11, 1'b0, 1'b0);   // R11 sentinel
      send(0, 18, 1'b1, 1'b1);   // R11 sentinel
      send(0, 17, 1'b1, 1'b0);   // R7
      idle(2);
      // full sweep, back-to-back, cpu alternating per combination
      for (int r = 0; r < 20; r++) begin
         for (int m = 0; m < 4; m++) begin
            send(0, r, m[1], m[0]);
            if (r < 13) send(1, r, m[0], m[1]);
         end
         if (r % 5 == 4) idle(2);
      end
      send(1, 31, 1'b1, 1'b1);
      send(0, 0, 1'b0, 1'b0);
      idle(4);
      if (exp_q.size() != 0) check(1'b0, "R2 missing response", 0, exp_q.size());
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule